// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a synchronous request port and an asynchronous 128K x 8 static RAM. A requester presents one word request at a time: a 17-bit word address, a write flag and, for writes, an 8-bit data byte. The controller accepts it with a valid/ready handshake, then drives the RAM's address, its two chip selects (one active low, one active high), its output enable and its write enable in a fixed sequence. For reads, it hands the captured byte back with a one-cycle valid pulse.

Every interval is set in nanoseconds through parameters: cycle time, write pulse, select-to-end-of-write, data setup, write recovery, access time and bus release time. Each is converted to a clock count by rounding up against the clock period. With the default 10 ns clock and the 100 ns speed grade, a write keeps the RAM selected for 10 cycles: 2 setup cycles, a 7-cycle write-enable pulse and 1 recovery cycle. A read keeps the RAM selected with output enable low for 10 cycles. Four dead cycles are inserted whenever the direction of the data bus changes. The pad tri-state buffer stays outside the block. The block supplies the data to drive and a drive-enable, and receives the sampled bus.

Top module: `sram_cycle_ctrl`

## Requirements
- R1: While idle and during reset, the RAM strobes rest at deselected levels (`ram_cs_n`=1, `ram_cs`=0, `ram_we_n`=1, `ram_oe_n`=1, `ram_dq_oe`=0), and `req_ready` is 1 whenever no transaction is running.
- R2: A write keeps the RAM selected for exactly 10 consecutive cycles. `ram_we_n` is low for exactly 7 of them, starting at the third selected cycle, so 2 setup cycles precede the pulse and 1 recovery cycle follows it.
- R3: During a write, `ram_dq_oe` is 1 and `ram_dq_out` holds the request's byte for every selected cycle. The byte is therefore stable at least 4 cycles before `ram_we_n` rises and is held after it rises. During a read, `ram_dq_oe` stays 0.
- R4: `ram_oe_n` stays 1 for the whole of a write. `ram_we_n` is never low while `ram_oe_n` is low, and `ram_dq_oe` is never 1 while `ram_oe_n` is low.
- R5: A read keeps the RAM selected with `ram_oe_n` low for exactly 10 cycles. The bus is sampled at the clock edge that ends the last of them. `rsp_valid` is 1 for exactly the following cycle and carries that byte on `rsp_rdata`.
- R6: `req_ready` is 0 from the cycle after acceptance until the RAM is deselected again.
- R7: When the direction of an accepted request differs from the previous transaction's direction, the RAM is selected 5 cycles after acceptance, leaving 4 deselected cycles. When the direction is the same, the RAM is selected in the cycle right after acceptance.
- R8: `ram_addr` equals the accepted address and stays unchanged for as long as the RAM is selected.
- R9: A byte written to any address is returned unchanged by a later read of that address.
- R10: The first transaction after reset starts without a turnaround gap, whatever its direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 8 | Byte to write |
| rsp_valid | output | 1 | One-cycle pulse: read data valid |
| rsp_rdata | output | 8 | Read data |
| ram_addr | output | 17 | RAM address lines |
| ram_cs_n | output | 1 | RAM active-low chip select |
| ram_cs | output | 1 | RAM active-high chip select |
| ram_oe_n | output | 1 | RAM output enable, active low |
| ram_we_n | output | 1 | RAM write enable, active low |
| ram_dq_out | output | 8 | Byte for the pad driver |
| ram_dq_oe | output | 1 | Pad driver enable |
| ram_dq_in | input | 8 | Sampled RAM data bus |

## Verification
The bench attaches a behavioural RAM that commits a byte only while both selects and write enable overlap. It measures the write pulse, the data-stable window and the selected time, and it flags a write attempted while output enable is low. A controller with an off-by-one timer would give a 6- or 8-cycle pulse or a 9-cycle read. The bench measures the gap between acceptance and select for every combination of directions, including the first request after reset. A missing turnaround would select the RAM one cycle after acceptance even when the direction flips. A spurious one would delay same-direction traffic or the first transaction. Random write-then-read traffic catches a capture taken one edge early (stale bus value) or data released before write enable rises.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_WSET,
    ST_WPUL,
    ST_WREC,
    ST_RACC
  } seq_state_e;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_RD,
    OP_WR
  } last_op_e;

  typedef struct packed {
    logic sel;
    logic we;
    logic oe;
    logic drv;
  } strobe_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // Strobe levels (active-high view) belonging to each sequencer state
  function automatic strobe_t strobe_of(input seq_state_e s);
    strobe_t r;
    r = '0;
    case (s)
      ST_WSET: begin r.sel = 1'b1; r.drv = 1'b1; end
      ST_WPUL: begin r.sel = 1'b1; r.drv = 1'b1; r.we = 1'b1; end
      ST_WREC: begin r.sel = 1'b1; r.drv = 1'b1; end
      ST_RACC: begin r.sel = 1'b1; r.oe = 1'b1; end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/sram_interval_timer.sv
module sram_interval_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] len,
  output logic          expired
);

  logic [TW-1:0] cnt_q;
  logic [TW-1:0] cnt_nx;

  // Loading len makes expired rise in the len-th cycle after the load edge
  always_comb begin
    cnt_nx = cnt_q;
    if (load)
      cnt_nx = len - TW'(1);
    else if (cnt_q != '0)
      cnt_nx = cnt_q - TW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else
      cnt_q <= cnt_nx;
  end

  assign expired = (cnt_q == '0);

endmodule

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int SET_CYC  = 2,
  parameter int WP_CYC   = 7,
  parameter int REC_CYC  = 1,
  parameter int ACC_CYC  = 10,
  parameter int TURN_CYC = 4,
  parameter int TW       = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          start_wr,
  input  logic          expired,
  output seq_state_e    state_nx,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_len,
  output logic          ready,
  output logic          capture
);

  localparam logic [TW-1:0] L_SET  = TW'(SET_CYC);
  localparam logic [TW-1:0] L_WP   = TW'(WP_CYC);
  localparam logic [TW-1:0] L_REC  = TW'(REC_CYC);
  localparam logic [TW-1:0] L_ACC  = TW'(ACC_CYC);
  localparam logic [TW-1:0] L_TURN = TW'(TURN_CYC);

  seq_state_e state_q;
  last_op_e   last_q, last_nx;
  logic       pend_wr_q, pend_wr_nx;
  logic       dir_flip;

  assign ready    = (state_q == ST_IDLE);
  assign dir_flip = (last_q != OP_NONE) && ((last_q == OP_WR) != start_wr);

  always_comb begin
    state_nx   = state_q;
    last_nx    = last_q;
    pend_wr_nx = pend_wr_q;
    tmr_load   = 1'b0;
    tmr_len    = L_SET;
    capture    = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          pend_wr_nx = start_wr;
          last_nx    = start_wr ? OP_WR : OP_RD;
          tmr_load   = 1'b1;
          if (dir_flip) begin
            state_nx = ST_TURN;
            tmr_len  = L_TURN;
          end else if (start_wr) begin
            state_nx = ST_WSET;
            tmr_len  = L_SET;
          end else begin
            state_nx = ST_RACC;
            tmr_len  = L_ACC;
          end
        end
      end
      ST_TURN: begin
        if (expired) begin
          tmr_load = 1'b1;
          if (pend_wr_q) begin
            state_nx = ST_WSET;
            tmr_len  = L_SET;
          end else begin
            state_nx = ST_RACC;
            tmr_len  = L_ACC;
          end
        end
      end
      ST_WSET: begin
        if (expired) begin
          state_nx = ST_WPUL;
          tmr_load = 1'b1;
          tmr_len  = L_WP;
        end
      end
      ST_WPUL: begin
        if (expired) begin
          state_nx = ST_WREC;
          tmr_load = 1'b1;
          tmr_len  = L_REC;
        end
      end
      ST_WREC: begin
        if (expired) state_nx = ST_IDLE;
      end
      ST_RACC: begin
        if (expired) begin
          state_nx = ST_IDLE;
          capture  = 1'b1;
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      last_q    <= OP_NONE;
      pend_wr_q <= 1'b0;
    end else begin
      state_q   <= state_nx;
      last_q    <= last_nx;
      pend_wr_q <= pend_wr_nx;
    end
  end

endmodule

// File: rtl/sram_cycle_ctrl.sv
module sram_cycle_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW        = 17,
  parameter int DW        = 8,
  parameter int CLK_NS    = 10,
  parameter int CYCLE_NS  = 100,
  parameter int WP_NS     = 70,
  parameter int CW_NS     = 85,
  parameter int SETUP_NS  = 40,
  parameter int WR_NS     = 5,
  parameter int ACC_NS    = 100,
  parameter int HZ_NS     = 35
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] ram_addr,
  output logic          ram_cs_n,
  output logic          ram_cs,
  output logic          ram_oe_n,
  output logic          ram_we_n,
  output logic [DW-1:0] ram_dq_out,
  output logic          ram_dq_oe,
  input  logic [DW-1:0] ram_dq_in
);

  localparam int CYC_CYC  = ceil_div(CYCLE_NS, CLK_NS);
  localparam int WP_CYC   = max2(ceil_div(WP_NS, CLK_NS), ceil_div(SETUP_NS, CLK_NS));
  localparam int CW_CYC   = ceil_div(CW_NS, CLK_NS);
  localparam int SET_CYC  = max2(1, CW_CYC - WP_CYC);
  localparam int REC_CYC  = max2(max2(1, ceil_div(WR_NS, CLK_NS)), CYC_CYC - SET_CYC - WP_CYC);
  localparam int ACC_CYC  = max2(ceil_div(ACC_NS, CLK_NS), CYC_CYC);
  localparam int TURN_CYC = max2(1, ceil_div(HZ_NS, CLK_NS));
  localparam int MAX_CYC  = max2(max2(max2(SET_CYC, WP_CYC), max2(REC_CYC, ACC_CYC)), TURN_CYC);
  localparam int TW       = $clog2(MAX_CYC + 1);

  // Reset: asserted asynchronously, released on the clock
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  seq_state_e    state_nx;
  logic          tmr_load, tmr_expired, capture, fsm_ready, accept;
  logic [TW-1:0] tmr_len;
  strobe_t       strb_nx;

  sram_cycle_fsm #(
    .SET_CYC (SET_CYC),
    .WP_CYC  (WP_CYC),
    .REC_CYC (REC_CYC),
    .ACC_CYC (ACC_CYC),
    .TURN_CYC(TURN_CYC),
    .TW      (TW)
  ) u_fsm (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start   (req_valid),
    .start_wr(req_write),
    .expired (tmr_expired),
    .state_nx(state_nx),
    .tmr_load(tmr_load),
    .tmr_len (tmr_len),
    .ready   (fsm_ready),
    .capture (capture)
  );

  sram_interval_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .load   (tmr_load),
    .len    (tmr_len),
    .expired(tmr_expired)
  );

  assign req_ready = fsm_ready;
  assign accept    = req_valid & fsm_ready;
  assign strb_nx   = strobe_of(state_nx);

  // Strobes registered from the next state: glitch-free pins
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ram_cs_n  <= 1'b1;
      ram_cs    <= 1'b0;
      ram_we_n  <= 1'b1;
      ram_oe_n  <= 1'b1;
      ram_dq_oe <= 1'b0;
    end else begin
      ram_cs_n  <= ~strb_nx.sel;
      ram_cs    <= strb_nx.sel;
      ram_we_n  <= ~strb_nx.we;
      ram_oe_n  <= ~strb_nx.oe;
      ram_dq_oe <= strb_nx.drv;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ram_addr   <= '0;
      ram_dq_out <= '0;
    end else if (accept) begin
      ram_addr   <= req_addr;
      ram_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= ram_dq_in;
    end
  end

endmodule

// File: rtl/sram_cycle_ctrl_chk.sv
module sram_cycle_ctrl_chk #(
  parameter int AW     = 17,
  parameter int WP_CYC = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_ready,
  input logic          rsp_valid,
  input logic [AW-1:0] ram_addr,
  input logic          ram_cs_n,
  input logic          ram_cs,
  input logic          ram_oe_n,
  input logic          ram_we_n,
  input logic          ram_dq_oe
);

  logic [7:0] we_low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      we_low_cnt <= '0;
    else if (!ram_we_n)
      we_low_cnt <= we_low_cnt + 8'd1;
    else
      we_low_cnt <= '0;
  end

  assert_idle_levels_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ram_cs_n && !ram_cs && ram_we_n && ram_oe_n && !ram_dq_oe));

  assert_selects_paired_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ram_cs_n != ram_cs);

  assert_we_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ram_we_n) |-> (we_low_cnt == 8'(WP_CYC)));

  assert_write_overlap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_we_n |-> (!ram_cs_n && ram_cs && ram_oe_n && ram_dq_oe));

  assert_no_contention_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ram_dq_oe && !ram_oe_n));

  assert_rvalid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  assert_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !ram_cs_n |-> !req_ready);

  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ram_cs_n && $past(!ram_cs_n)) |-> $stable(ram_addr));

endmodule

bind sram_cycle_ctrl sram_cycle_ctrl_chk #(.AW(AW), .WP_CYC(WP_CYC)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .rsp_valid(rsp_valid),
  .ram_addr (ram_addr),
  .ram_cs_n (ram_cs_n),
  .ram_cs   (ram_cs),
  .ram_oe_n (ram_oe_n),
  .ram_we_n (ram_we_n),
  .ram_dq_oe(ram_dq_oe)
);

// File: tb/sram_cycle_ctrl_test.sv
module sram_cycle_ctrl_test;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [16:0] req_addr;
  logic [7:0]  req_wdata;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [16:0] ram_addr;
  logic        ram_cs_n, ram_cs, ram_oe_n, ram_we_n, ram_dq_oe;
  logic [7:0]  ram_dq_out, ram_dq_in;

  int total = 0;
  int bad   = 0;
  int last_dir = -1;  // -1 none, 0 read, 1 write

  logic [7:0] mem [int];
  logic [7:0] exp_mem [int];

  always #2 clk = ~clk;

  sram_cycle_ctrl uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .ram_addr(ram_addr), .ram_cs_n(ram_cs_n), .ram_cs(ram_cs),
    .ram_oe_n(ram_oe_n), .ram_we_n(ram_we_n),
    .ram_dq_out(ram_dq_out), .ram_dq_oe(ram_dq_oe), .ram_dq_in(ram_dq_in)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural RAM
  function automatic logic [7:0] ram_read(input logic [16:0] a);
    if (mem.exists(int'(a))) return mem[int'(a)];
    return ~a[7:0];
  endfunction

  logic sel;
  assign sel = !ram_cs_n && ram_cs;
  assign ram_dq_in = (sel && !ram_oe_n && ram_we_n) ? ram_read(ram_addr) : 8'h00;

  int we_run = 0, sel_run = 0, stable_run = 0;
  logic [7:0] prev_out = 8'h00;

  always @(negedge clk) begin
    if (rst_n) begin
      if (ram_dq_oe && ram_dq_out == prev_out) stable_run++;
      else stable_run = ram_dq_oe ? 1 : 0;
      prev_out = ram_dq_out;
      if (sel && !ram_we_n) begin
        we_run++;
        if (!ram_oe_n) chk(0, "R4 model: write while OE low", 1, 0);
      end else if (we_run > 0) begin
        chk(we_run == 7, "R2 model: write pulse cycles", we_run, 7);
        chk(stable_run >= 5, "R3 model: data stable cycles at WE rise", stable_run, 5);
        if (sel) mem[int'(ram_addr)] = ram_dq_out;
        we_run = 0;
      end
      if (sel) sel_run++;
      else if (sel_run > 0) begin
        chk(sel_run >= 10, "R2/R5 model: cycle time", sel_run, 10);
        sel_run = 0;
      end
    end
  end

  // One transaction, measured at the pins
  task automatic do_op(input bit wr, input logic [16:0] a, input logic [7:0] d);
    int lat, act, we_first, we_cnt, oe_cnt, rdy_bad, addr_bad, drv_bad, exp_lat;
    logic [7:0] exp_rd;
    exp_lat = (last_dir >= 0 && last_dir != int'(wr)) ? 4 : 0;
    exp_rd  = exp_mem.exists(int'(a)) ? exp_mem[int'(a)] : ~a[7:0];
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_addr = ~a; req_wdata = ~d;
    chk(!req_ready, "R6 ready low after accept", req_ready, 0);
    lat = 0;
    while (ram_cs_n && lat < 20) begin lat++; @(negedge clk); end
    chk(lat == exp_lat, wr ? "R7/R10 gap before write" : "R7/R10 gap before read", lat, exp_lat);
    act = 0; we_first = -1; we_cnt = 0; oe_cnt = 0; rdy_bad = 0; addr_bad = 0; drv_bad = 0;
    while (!ram_cs_n && act < 40) begin
      if (req_ready) rdy_bad++;
      if (!ram_we_n) begin if (we_first < 0) we_first = act; we_cnt++; end
      if (!ram_oe_n) oe_cnt++;
      if (ram_addr != a) addr_bad++;
      if (wr && (!ram_dq_oe || ram_dq_out != d)) drv_bad++;
      if (!wr && ram_dq_oe) drv_bad++;
      act++;
      @(negedge clk);
    end
    chk(act == 10, "R2/R5 selected cycles", act, 10);
    chk(rdy_bad == 0, "R6 ready while selected", rdy_bad, 0);
    chk(addr_bad == 0, "R8 address held", addr_bad, 0);
    chk(drv_bad == 0, "R3 data drive", drv_bad, 0);
    chk(req_ready, "R1 ready after transaction", req_ready, 1);
    if (wr) begin
      chk(we_cnt == 7, "R2 WE low cycles", we_cnt, 7);
      chk(we_first == 2, "R2 WE start cycle", we_first, 2);
      chk(oe_cnt == 0, "R4 OE during write", oe_cnt, 0);
      exp_mem[int'(a)] = d;
    end else begin
      chk(oe_cnt == 10, "R5 OE low cycles", oe_cnt, 10);
      chk(we_cnt == 0, "R4 WE during read", we_cnt, 0);
      chk(rsp_valid, "R5 rvalid after read", rsp_valid, 1);
      chk(rsp_rdata == exp_rd, "R9 read data", rsp_rdata, exp_rd);
      @(negedge clk);
      chk(!rsp_valid, "R5 rvalid one cycle", rsp_valid, 0);
    end
    last_dir = int'(wr);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    last_dir = -1;
    repeat (3) @(negedge clk);
    chk(ram_cs_n && !ram_cs && ram_we_n && ram_oe_n && !ram_dq_oe,
        "R1 strobes in reset", {ram_cs_n, ram_cs, ram_we_n, ram_oe_n, ram_dq_oe}, 5'b10110);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready, "R1 ready after reset", req_ready, 1);
    chk(!rsp_valid, "R1 no rvalid after reset", rsp_valid, 0);
  endtask

  task automatic t_first_read;   // R10: read first
    do_op(1'b0, 17'h1ABCD, 8'h00);
  endtask

  task automatic t_first_write;  // R10: write first
    do_op(1'b1, 17'h00010, 8'h5A);
  endtask

  task automatic t_same_dir;     // R7 same direction, no gap
    do_op(1'b1, 17'h1FFFF, 8'hFF);
    do_op(1'b1, 17'h00000, 8'h00);
    do_op(1'b1, 17'h0AAAA, 8'hA5);
  endtask

  task automatic t_turnaround;   // R7 direction changes
    do_op(1'b0, 17'h1FFFF, 8'h00);
    do_op(1'b0, 17'h00000, 8'h00);
    do_op(1'b1, 17'h0AAAA, 8'h3C);
    do_op(1'b0, 17'h0AAAA, 8'h00);
  endtask

  task automatic t_random;       // R9 random write then readback
    logic [16:0] addrs [16];
    for (int i = 0; i < 16; i++) begin
      addrs[i] = 17'($urandom);
      do_op(1'b1, addrs[i], 8'($urandom));
    end
    for (int i = 15; i >= 0; i--) do_op(1'b0, addrs[i], 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R6 watchdog expired", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(7));
    t_reset();
    t_first_read();
    t_reset();
    t_first_write();
    t_same_dir();
    t_turnaround();
    t_random();
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule